// File: doc/BRIEF.md
# Debug Serial Port Receiver

This block receives frames from an external debug tool over a one-wire serial data line. Each frame carries a kind flag and a 32-bit payload. The flag marks the frame as either an instruction or a data word. Completed frames go to the core with a one-cycle valid pulse. The core states what it is waiting for by pulsing a request input. When a finished frame is of the other kind, the block raises a one-cycle sequence-error pulse, which the transmit side can forward to the tool.

The block has two bit-clocking schemes, and the choice is made once after each reset from the level of the data line. In the external-clock scheme, the tool supplies its own serial clock. That clock and the data line are both synchronized into the system clock domain, and a bit is taken on each rising edge of the synchronized serial clock. In the self-clock scheme, a bit is taken on every system clock. Start-bit detection is held off for a fixed time after reset, so that the level used to pick the clock mode is not mistaken for a start bit. After the hold-off, the block also waits until the line is low before it looks for a start bit.

Top module: `dbg_serial_rx`

## Requirements
- R1: While `rst` is high (synchronous, active high), `frame_valid`, `seq_error`, `rx_armed` and `mode_self` are all 0 from the first clock edge onward.
- R2: Count system clock rising edges from the first edge with `rst` low as edge 1. On edge 8, the level of `ser_din` is latched as the clock mode. A 1 selects self-clock mode (`mode_self`=1) and a 0 selects external-clock mode (`mode_self`=0). `mode_self` reads 0 before edge 8.
- R3: The latched mode does not change until the next reset, whatever `ser_din` does afterwards.
- R4: In external-clock mode, one bit is taken for each rising edge of `ser_clk`, after synchronization. The bit is the synchronized `ser_din` level at that edge. Changes on `ser_din` with no `ser_clk` edge produce no bits.
- R5: In self-clock mode, one bit is taken on every system clock rising edge, so the bit rate equals the system clock rate.
- R6: `rx_armed` stays 0 through edge 16. If the data line is low at edge 17, `rx_armed` becomes 1 on edge 17. No start bit is accepted while `rx_armed` is 0.
- R7: If the data line is high when the hold-off ends, `rx_armed` stays 0 until a low level is seen. Once set, it stays 1 until reset.
- R8: A frame is made of the following bits, in order:
  - a start bit of 1;
  - a kind flag (0 = instruction, 1 = data);
  - 32 payload bits, MSB first.

  `frame_valid` is high for exactly one system clock, starting on the edge that takes the last payload bit. While it is high, `frame_is_data` and `frame_payload` hold that frame's values.
- R9: `seq_error` pulses together with `frame_valid` when a request is pending and the frame's kind flag differs from the requested kind. It stays 0 when the kinds match or when no request is pending.
- R10: A one-cycle pulse on `expect_instr` or `expect_data` makes an instruction or a data request pending. If both are high, `expect_instr` wins. Each completed frame clears the pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Tool-supplied serial clock (external-clock mode) |
| ser_din | input | 1 | Serial data line; also picks the clock mode after reset |
| expect_instr | input | 1 | Core pulses to request an instruction frame |
| expect_data | input | 1 | Core pulses to request a data frame |
| mode_self | output | 1 | 1 = self-clock mode latched, 0 = external-clock mode |
| rx_armed | output | 1 | Start-bit search enabled |
| frame_valid | output | 1 | One-cycle pulse when a frame completes |
| frame_is_data | output | 1 | Kind flag of the last frame (1 = data) |
| frame_payload | output | 32 | Payload of the last frame |
| seq_error | output | 1 | One-cycle pulse on a kind mismatch |

## Verification
The bench builds the block with its default parameters:
- 32-bit payload;
- mode sample on edge 8;
- hold-off of 16 edges;
- two synchronizer stages.

With these values, the mode latch and the arming edge can be checked edge by edge against the fixed counts in the requirements. The external-clock path then has exactly two cycles of latency, which the serial-clock generator in the bench leaves margin around. Payloads with only the MSB set, and with only the LSB set, confirm the bit order at both ends of the shift register.

// File: rtl/dbg_rx_pkg.sv
package dbg_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_FLAG = 2'd1,
    RX_DATA = 2'd2
  } rx_state_e;

  typedef enum logic {
    KIND_INSTR = 1'b0,
    KIND_DATA  = 1'b1
  } frame_kind_e;
endpackage

// File: rtl/dbg_rx_startup.sv
module dbg_rx_startup #(
  parameter int MODE_SAMPLE_CYC = 8,
  parameter int HOLDOFF_CYC     = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic din_pin,
  input  logic din_level,
  output logic mode_self,
  output logic armed
);
  localparam int CW = $clog2(HOLDOFF_CYC + 1);
  localparam logic [CW-1:0] HOLD_VAL   = CW'(HOLDOFF_CYC);
  localparam logic [CW-1:0] SAMPLE_VAL = CW'(MODE_SAMPLE_CYC - 1);

  logic [CW-1:0] since_rst;
  logic          holdoff_done;

  assign holdoff_done = (since_rst == HOLD_VAL);

  // cycles since reset negation, saturating at the hold-off length
  always_ff @(posedge clk) begin
    if (rst) begin
      since_rst <= '0;
    end else if (!holdoff_done) begin
      since_rst <= since_rst + 1'b1;
    end
  end

  // clock mode captured once from the raw pin
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_self <= 1'b0;
    end else if (since_rst == SAMPLE_VAL) begin
      mode_self <= din_pin;
    end
  end

  // start-bit search opens after hold-off once the line is low
  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
    end else if (holdoff_done && !din_level) begin
      armed <= 1'b1;
    end
  end

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (since_rst > SAMPLE_VAL) |=> $stable(mode_self)); // R3

  AST_ARM_AFTER_HOLDOFF: assert property (@(posedge clk) disable iff (rst)
    armed |-> holdoff_done); // R6

  AST_ARM_STICKY: assert property (@(posedge clk) disable iff (rst)
    armed |=> armed); // R7
endmodule

// File: rtl/dbg_rx_bitclk.sv
module dbg_rx_bitclk #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_self,
  input  logic ser_clk,
  input  logic ser_din,
  output logic bit_vld,
  output logic bit_val,
  output logic din_level
);
  logic [SYNC_STAGES:0]   sck_q;
  logic [SYNC_STAGES-1:0] din_q;
  logic                   sck_rise;
  logic                   din_sync;

  // serial clock chain: SYNC_STAGES synchronizer flops plus one for edge detect
  for (genvar g = 0; g <= SYNC_STAGES; g++) begin : g_sck
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) sck_q[0] <= 1'b0;
        else     sck_q[0] <= ser_clk;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) sck_q[g] <= 1'b0;
        else     sck_q[g] <= sck_q[g-1];
      end
    end
  end

  // data chain matched to the clock synchronizer latency
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_din
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) din_q[0] <= 1'b0;
        else     din_q[0] <= ser_din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) din_q[g] <= 1'b0;
        else     din_q[g] <= din_q[g-1];
      end
    end
  end

  assign sck_rise = sck_q[SYNC_STAGES-1] & ~sck_q[SYNC_STAGES];
  assign din_sync = din_q[SYNC_STAGES-1];

  always_comb begin
    if (mode_self) begin
      bit_vld   = 1'b1;
      bit_val   = ser_din;
      din_level = ser_din;
    end else begin
      bit_vld   = sck_rise;
      bit_val   = din_sync;
      din_level = din_sync;
    end
  end

  AST_EXT_EDGE_SPACING: assert property (@(posedge clk) disable iff (rst)
    (!mode_self && bit_vld) |=> (mode_self || !bit_vld)); // R4
endmodule

// File: rtl/dbg_rx_shifter.sv
module dbg_rx_shifter
  import dbg_rx_pkg::*;
#(
  parameter int PAYLOAD_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 armed,
  input  logic                 bit_vld,
  input  logic                 bit_val,
  output logic                 done,
  output logic                 done_kind,
  output logic                 frame_valid,
  output logic                 frame_kind,
  output logic [PAYLOAD_W-1:0] frame_payload
);
  localparam int BW = $clog2(PAYLOAD_W);
  localparam logic [BW-1:0] LAST_BIT = BW'(PAYLOAD_W - 1);

  rx_state_e            state;
  logic [BW-1:0]        bcnt;
  logic                 kind_q;
  logic [PAYLOAD_W-1:0] shreg;

  assign done      = (state == RX_DATA) && bit_vld && (bcnt == LAST_BIT);
  assign done_kind = kind_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= RX_IDLE;
      bcnt   <= '0;
      kind_q <= 1'b0;
      shreg  <= '0;
    end else if (bit_vld) begin
      unique case (state)
        RX_IDLE: if (armed && bit_val) state <= RX_FLAG;
        RX_FLAG: begin
          kind_q <= bit_val;
          bcnt   <= '0;
          state  <= RX_DATA;
        end
        RX_DATA: begin
          shreg <= {shreg[PAYLOAD_W-2:0], bit_val};
          bcnt  <= bcnt + 1'b1;
          if (bcnt == LAST_BIT) state <= RX_IDLE;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_valid   <= 1'b0;
      frame_kind    <= 1'b0;
      frame_payload <= '0;
    end else begin
      frame_valid <= done;
      if (done) begin
        frame_kind    <= kind_q;
        frame_payload <= {shreg[PAYLOAD_W-2:0], bit_val};
      end
    end
  end

  AST_FV_SINGLE: assert property (@(posedge clk) disable iff (rst)
    frame_valid |=> !frame_valid); // R8

  AST_IDLE_UNARMED: assert property (@(posedge clk) disable iff (rst)
    !armed |-> (state == RX_IDLE)); // R6
endmodule

// File: rtl/dbg_serial_rx.sv
module dbg_serial_rx
  import dbg_rx_pkg::*;
#(
  parameter int PAYLOAD_W       = 32,
  parameter int MODE_SAMPLE_CYC = 8,
  parameter int HOLDOFF_CYC     = 16,
  parameter int SYNC_STAGES     = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ser_clk,
  input  logic                 ser_din,
  input  logic                 expect_instr,
  input  logic                 expect_data,
  output logic                 mode_self,
  output logic                 rx_armed,
  output logic                 frame_valid,
  output logic                 frame_is_data,
  output logic [PAYLOAD_W-1:0] frame_payload,
  output logic                 seq_error
);
  logic bit_vld, bit_val, din_level;
  logic done, done_kind;
  logic req_pend;
  logic req_kind;

  dbg_rx_startup #(
    .MODE_SAMPLE_CYC(MODE_SAMPLE_CYC),
    .HOLDOFF_CYC    (HOLDOFF_CYC)
  ) u_startup (
    .clk      (clk),
    .rst      (rst),
    .din_pin  (ser_din),
    .din_level(din_level),
    .mode_self(mode_self),
    .armed    (rx_armed)
  );

  dbg_rx_bitclk #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_bitclk (
    .clk      (clk),
    .rst      (rst),
    .mode_self(mode_self),
    .ser_clk  (ser_clk),
    .ser_din  (ser_din),
    .bit_vld  (bit_vld),
    .bit_val  (bit_val),
    .din_level(din_level)
  );

  dbg_rx_shifter #(
    .PAYLOAD_W(PAYLOAD_W)
  ) u_shifter (
    .clk          (clk),
    .rst          (rst),
    .armed        (rx_armed),
    .bit_vld      (bit_vld),
    .bit_val      (bit_val),
    .done         (done),
    .done_kind    (done_kind),
    .frame_valid  (frame_valid),
    .frame_kind   (frame_is_data),
    .frame_payload(frame_payload)
  );

  // outstanding core request; a completed frame consumes it
  always_ff @(posedge clk) begin
    if (rst) begin
      req_pend <= 1'b0;
      req_kind <= KIND_INSTR;
    end else begin
      if (done) req_pend <= 1'b0;
      if (expect_instr) begin
        req_pend <= 1'b1;
        req_kind <= KIND_INSTR;
      end else if (expect_data) begin
        req_pend <= 1'b1;
        req_kind <= KIND_DATA;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) seq_error <= 1'b0;
    else     seq_error <= done && req_pend && (done_kind != req_kind);
  end

  AST_SEQERR_WITH_FRAME: assert property (@(posedge clk) disable iff (rst)
    seq_error |-> frame_valid); // R9

  AST_SEQERR_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    seq_error |-> $past(req_pend)); // R10
endmodule

// File: tb/dbg_serial_rx_test.sv
module dbg_serial_rx_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ser_clk = 1'b0;
  logic        ser_din = 1'b0;
  logic        expect_instr = 1'b0;
  logic        expect_data = 1'b0;
  logic        mode_self, rx_armed, frame_valid, frame_is_data, seq_error;
  logic [31:0] frame_payload;

  int n_checks = 0;
  int n_fail   = 0;
  int fv_cnt   = 0;
  int err_cnt  = 0;
  logic [31:0] cap_pl;
  logic        cap_kind;
  logic        cap_err;

  always #5 clk = ~clk;

  dbg_serial_rx uut (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_din(ser_din),
    .expect_instr(expect_instr), .expect_data(expect_data),
    .mode_self(mode_self), .rx_armed(rx_armed), .frame_valid(frame_valid),
    .frame_is_data(frame_is_data), .frame_payload(frame_payload),
    .seq_error(seq_error)
  );

  // capture pulses away from the active edge
  always @(negedge clk) begin
    if (frame_valid) begin
      fv_cnt++;
      cap_pl   = frame_payload;
      cap_kind = frame_is_data;
      cap_err  = seq_error;
    end
    if (seq_error) err_cnt++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic edge_sample();
    @(posedge clk); #1;
  endtask

  task automatic do_reset(input logic din_val);
    @(negedge clk);
    rst = 1'b1; ser_din = din_val; ser_clk = 1'b0;
    expect_instr = 1'b0; expect_data = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic send_bit(input logic b, input bit ext);
    @(negedge clk);
    ser_din = b;
    if (ext) begin
      repeat (2) @(negedge clk);
      ser_clk = 1'b1;
      repeat (3) @(negedge clk);
      ser_clk = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic send_frame(input logic kind, input logic [31:0] pl, input bit ext);
    send_bit(1'b1, ext);
    send_bit(kind, ext);
    for (int i = 31; i >= 0; i--) send_bit(pl[i], ext);
    @(negedge clk);
    ser_din = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse_req(input bit data);
    @(negedge clk);
    if (data) expect_data = 1'b1; else expect_instr = 1'b1;
    @(negedge clk);
    expect_data = 1'b0; expect_instr = 1'b0;
  endtask

  task automatic frame_case(input string req, input logic kind, input logic [31:0] pl,
                            input bit ext, input logic exp_err);
    int fv0 = fv_cnt;
    int er0 = err_cnt;
    send_frame(kind, pl, ext);
    chk(fv_cnt == fv0 + 1, req, "frame_valid pulse count", 32'(fv_cnt - fv0), 32'd1);
    chk(cap_pl == pl, req, "payload", cap_pl, pl);
    chk(cap_kind == kind, req, "kind flag", {31'd0, cap_kind}, {31'd0, kind});
    chk(cap_err == exp_err && (err_cnt - er0) == int'(exp_err), "R9", "seq_error",
        {31'd0, cap_err}, {31'd0, exp_err});
  endtask

  task automatic t_reset_state();
    @(negedge clk); rst = 1'b1; ser_din = 1'b1;
    repeat (2) edge_sample();
    chk({frame_valid, seq_error, rx_armed, mode_self} == 4'b0, "R1", "outputs in reset",
        {28'd0, frame_valid, seq_error, rx_armed, mode_self}, 32'd0);
  endtask

  task automatic t_self_mode_startup();
    do_reset(1'b1);
    repeat (7) edge_sample();
    chk(mode_self == 1'b0, "R2", "mode before edge 8", {31'd0, mode_self}, 32'd0);
    edge_sample();
    chk(mode_self == 1'b1, "R2", "self mode after edge 8", {31'd0, mode_self}, 32'd1);
    repeat (8) edge_sample();
    chk(rx_armed == 1'b0, "R6", "armed at edge 16", {31'd0, rx_armed}, 32'd0);
    repeat (4) edge_sample();
    chk(rx_armed == 1'b0, "R7", "armed while line high", {31'd0, rx_armed}, 32'd0);
    @(negedge clk); ser_din = 1'b0;
    edge_sample();
    chk(rx_armed == 1'b1, "R7", "armed after line low", {31'd0, rx_armed}, 32'd1);
    repeat (5) edge_sample();
    chk(mode_self == 1'b1, "R3", "mode held after din low", {31'd0, mode_self}, 32'd1);
  endtask

  task automatic t_self_frames();
    frame_case("R8", 1'b0, 32'hDEADBEEF, 1'b0, 1'b0);
    pulse_req(1'b1);
    frame_case("R9", 1'b0, 32'h12345678, 1'b0, 1'b1);
    pulse_req(1'b0);
    frame_case("R5", 1'b0, 32'hCAFE0001, 1'b0, 1'b0);
    pulse_req(1'b0);
    frame_case("R9", 1'b1, 32'h00000001, 1'b0, 1'b1);
    pulse_req(1'b1);
    frame_case("R8", 1'b1, 32'h80000000, 1'b0, 1'b0);
    // R10: request consumed, so a mismatching frame now raises nothing
    frame_case("R10", 1'b0, 32'h0F0F0F0F, 1'b0, 1'b0);
    // R10: both request lines high resolves to instruction
    @(negedge clk); expect_instr = 1'b1; expect_data = 1'b1;
    @(negedge clk); expect_instr = 1'b0; expect_data = 1'b0;
    frame_case("R10", 1'b1, 32'h55AA55AA, 1'b0, 1'b1);
  endtask

  task automatic t_ext_mode();
    int fv0;
    do_reset(1'b0);
    repeat (8) edge_sample();
    chk(mode_self == 1'b0, "R2", "external mode after edge 8", {31'd0, mode_self}, 32'd0);
    repeat (8) edge_sample();
    chk(rx_armed == 1'b0, "R6", "armed at edge 16", {31'd0, rx_armed}, 32'd0);
    edge_sample();
    chk(rx_armed == 1'b1, "R6", "armed at edge 17", {31'd0, rx_armed}, 32'd1);
    fv0 = fv_cnt;
    @(negedge clk);
    for (int i = 0; i < 80; i++) begin
      ser_din = ~ser_din;
      @(negedge clk);
    end
    ser_din = 1'b0;
    repeat (6) @(negedge clk);
    chk(fv_cnt == fv0, "R4", "no frame without serial clock", 32'(fv_cnt - fv0), 32'd0);
    chk(mode_self == 1'b0, "R3", "mode held after din toggling", {31'd0, mode_self}, 32'd0);
    pulse_req(1'b1);
    frame_case("R4", 1'b1, 32'hA5C30F96, 1'b1, 1'b0);
    pulse_req(1'b0);
    frame_case("R4", 1'b1, 32'h7FFFFFFE, 1'b1, 1'b1);
  endtask

  task automatic t_rereset();
    @(negedge clk); rst = 1'b1; ser_din = 1'b1;
    edge_sample();
    chk(rx_armed == 1'b0 && mode_self == 1'b0, "R1", "re-reset clears state",
        {30'd0, rx_armed, mode_self}, 32'd0);
  endtask

  task automatic finish_up();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #1_500_000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    t_reset_state();
    t_self_mode_startup();
    t_self_frames();
    t_ext_mode();
    t_rereset();
    finish_up();
  end
endmodule